// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks which of eight interrupt request lines should be offered to the processor. The surrounding controller keeps the request, mask and in-service registers and supplies them here. It also supplies a rotation offset and two mode flags: one marks the controller as the master of a cascade, the other enables special nesting. Priority moves round a ring. The offset names the line that currently holds top priority, and the remaining lines follow it in ascending order with wrap-around.

A request is offered only if it outranks everything already in service. In special nesting on the master, the cascade line is left out of that in-service comparison, so a second request arriving through the slave can still get through. A second output gives the top-priority line that is currently in service. The controller uses it to decide which bit a nonspecific end-of-interrupt clears.

All outputs are registered and follow the inputs one clock later. They are plain level pins. There is no handshake, so no back-pressure applies: the consumer samples the outputs whenever it needs them.

Top module: `rpr_top`

## Requirements
- R1: A line is a candidate only if its request bit is 1 and its mask bit is 0. A masked line or a line with no request is never reported.
- R2: Rank p belongs to line (p + offset) mod 8, and rank 0 is the highest. With offset 0, line 0 wins over every other line. With offset k, line k wins over every other line.
- R3: When there is no candidate, `irq_valid_o` is 0.
- R4: The best candidate is reported only if its rank is strictly lower than the best rank present in the in-service register. An equal or poorer rank gives `irq_valid_o` = 0. An empty in-service register lets any candidate through.
- R5: When `nest_mode_i`=1 and `is_master_i`=1, in-service bit 2 (the cascade line) takes no part in the R4 comparison. In every other mode combination it does take part.
- R6: `irq_num_o` is (winning rank + offset) mod 8, which is the line number of the winner.
- R7: `isr_top_valid_o` is 1 exactly when the in-service register is nonzero. `isr_top_num_o` is then the in-service line with the best rank under the same rotation. Bit 2 is always included here, whatever the mode.
- R8: Every output reflects the inputs sampled at the previous rising clock edge. A change on an input has no effect on the outputs until the next rising edge.
- R9: While `rst_n` is low, `irq_valid_o`, `isr_top_valid_o`, `irq_num_o` and `isr_top_num_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request register, bit n = line n |
| mask_i | input | 8 | Mask register, 1 blocks the line |
| insvc_i | input | 8 | In-service register |
| rot_ofs_i | input | 3 | Line holding rank 0 |
| nest_mode_i | input | 1 | Special nesting enable |
| is_master_i | input | 1 | 1 when this controller is the cascade master |
| irq_valid_o | output | 1 | A line should be offered to the processor |
| irq_num_o | output | 3 | Line number to offer |
| isr_top_valid_o | output | 1 | In-service register is nonzero |
| isr_top_num_o | output | 3 | Best-ranked line in service |

## Verification
The bench aims at the wrap-around points of the rotation. An encoder that ignored the offset, or mapped the rank back the wrong way, would report the wrong line once the offset is nonzero. It checks that a candidate and an in-service bit of equal rank block each other; a resolver using a non-strict comparison would re-offer a line that is already being served. The cascade exclusion is tested on the master and on the slave, and with nesting on and off, to catch a design that drops bit 2 in the wrong mode or also drops it in the end-of-interrupt helper. It also tests a masked request that is ranked above every other request, and an input change between clock edges, which must not reach the outputs early.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  parameter int unsigned RPR_LINES = 8;
  localparam int unsigned RPR_IDX_W = $clog2(RPR_LINES);
  typedef logic [RPR_IDX_W-1:0] rpr_idx_t;
  typedef logic [RPR_LINES-1:0] rpr_vec_t;
  typedef struct packed {
    logic     hit;
    rpr_idx_t line;
  } rpr_pick_t;
endpackage

// File: rtl/rpr_rank_find.sv
module rpr_rank_find #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] ofs_i,
  output logic          hit_o,
  output logic [IW-1:0] rank_o
);
  logic [N-1:0] rot;

  // rot[p] holds the bit of the line at rank p
  for (genvar g = 0; g < N; g++) begin : g_rot
    assign rot[g] = vec_i[IW'(g) + ofs_i];
  end

  always_comb begin
    hit_o  = |rot;
    rank_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank_o = IW'(i);
    end
  end
endmodule

// File: rtl/rpr_resolve.sv
module rpr_resolve
  import rpr_pkg::*;
#(
  parameter int unsigned CASCADE_LINE = 2
) (
  input  rpr_vec_t  req_i,
  input  rpr_vec_t  mask_i,
  input  rpr_vec_t  insvc_i,
  input  rpr_idx_t  ofs_i,
  input  logic      nest_mode_i,
  input  logic      is_master_i,
  output rpr_pick_t irq_o,
  output rpr_pick_t isr_top_o
);
  rpr_vec_t cand, insvc_cmp, casc_bit;
  logic     c_hit, s_hit, t_hit;
  rpr_idx_t c_rank, s_rank, t_rank;

  assign casc_bit  = rpr_vec_t'(1) << CASCADE_LINE;
  assign cand      = req_i & ~mask_i;
  assign insvc_cmp = (nest_mode_i && is_master_i) ? (insvc_i & ~casc_bit) : insvc_i;

  rpr_rank_find #(.N(RPR_LINES), .IW(RPR_IDX_W)) u_cand (
    .vec_i(cand), .ofs_i(ofs_i), .hit_o(c_hit), .rank_o(c_rank));
  rpr_rank_find #(.N(RPR_LINES), .IW(RPR_IDX_W)) u_cmp (
    .vec_i(insvc_cmp), .ofs_i(ofs_i), .hit_o(s_hit), .rank_o(s_rank));
  rpr_rank_find #(.N(RPR_LINES), .IW(RPR_IDX_W)) u_top (
    .vec_i(insvc_i), .ofs_i(ofs_i), .hit_o(t_hit), .rank_o(t_rank));

  always_comb begin
    irq_o.hit      = c_hit && (!s_hit || (c_rank < s_rank));
    irq_o.line     = c_rank + ofs_i;
    isr_top_o.hit  = t_hit;
    isr_top_o.line = t_rank + ofs_i;
  end
endmodule

// File: rtl/rpr_top.sv
module rpr_top
  import rpr_pkg::*;
#(
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RPR_LINES-1:0] req_i,
  input  logic [RPR_LINES-1:0] mask_i,
  input  logic [RPR_LINES-1:0] insvc_i,
  input  logic [RPR_IDX_W-1:0] rot_ofs_i,
  input  logic                 nest_mode_i,
  input  logic                 is_master_i,
  output logic                 irq_valid_o,
  output logic [RPR_IDX_W-1:0] irq_num_o,
  output logic                 isr_top_valid_o,
  output logic [RPR_IDX_W-1:0] isr_top_num_o
);
  rpr_pick_t irq_d, top_d, irq_q, top_q;

  rpr_resolve #(.CASCADE_LINE(CASCADE_LINE)) u_res (
    .req_i(req_i), .mask_i(mask_i), .insvc_i(insvc_i), .ofs_i(rot_ofs_i),
    .nest_mode_i(nest_mode_i), .is_master_i(is_master_i),
    .irq_o(irq_d), .isr_top_o(top_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      top_q <= '0;
    end else begin
      irq_q <= irq_d;
      top_q <= top_d;
    end
  end

  assign irq_valid_o     = irq_q.hit;
  assign irq_num_o       = irq_q.line;
  assign isr_top_valid_o = top_q.hit;
  assign isr_top_num_o   = top_q.line;
endmodule

// File: rtl/rpr_chk.sv
module rpr_chk
  import rpr_pkg::*;
#(
  parameter int unsigned CASCADE_LINE = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [RPR_LINES-1:0] req_i,
  input logic [RPR_LINES-1:0] mask_i,
  input logic [RPR_LINES-1:0] insvc_i,
  input logic                 nest_mode_i,
  input logic                 is_master_i,
  input logic                 irq_valid_o,
  input logic [RPR_IDX_W-1:0] irq_num_o,
  input logic                 isr_top_valid_o,
  input logic [RPR_IDX_W-1:0] isr_top_num_o
);
  rpr_vec_t req_q, mask_q, isr_q;
  logic     nest_q, mst_q;

  always_ff @(posedge clk) begin
    req_q  <= req_i;
    mask_q <= mask_i;
    isr_q  <= insvc_i;
    nest_q <= nest_mode_i;
    mst_q  <= is_master_i;
  end

  assert_candidate_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (req_q[irq_num_o] && !mask_q[irq_num_o]));

  assert_idle_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & ~mask_i) == '0) |=> !irq_valid_o);

  assert_strict_outrank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !(nest_q && mst_q && (irq_num_o == RPR_IDX_W'(CASCADE_LINE))))
      |-> !isr_q[irq_num_o]);

  assert_cascade_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_mode_i && is_master_i && (insvc_i == (rpr_vec_t'(1) << CASCADE_LINE))
      && ((req_i & ~mask_i) != '0)) |=> irq_valid_o);

  assert_top_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr_top_valid_o |-> isr_q[isr_top_num_o]);

  assert_top_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_i == '0) |=> !isr_top_valid_o);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!irq_valid_o && !isr_top_valid_o));
endmodule

bind rpr_top rpr_chk #(.CASCADE_LINE(CASCADE_LINE)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .insvc_i(insvc_i),
  .nest_mode_i(nest_mode_i), .is_master_i(is_master_i),
  .irq_valid_o(irq_valid_o), .irq_num_o(irq_num_o),
  .isr_top_valid_o(isr_top_valid_o), .isr_top_num_o(isr_top_num_o));

// File: tb/rpr_top_tb_top.sv
`timescale 1ns/100ps
module rpr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr = '0;
  logic [2:0] ofs = '0;
  logic       nest = 1'b0, mst = 1'b0;
  logic       irq_valid, top_valid;
  logic [2:0] irq_num, top_num;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rpr_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(isr),
    .rot_ofs_i(ofs), .nest_mode_i(nest), .is_master_i(mst),
    .irq_valid_o(irq_valid), .irq_num_o(irq_num),
    .isr_top_valid_o(top_valid), .isr_top_num_o(top_num));

  function automatic int rank_of(logic [7:0] v, logic [2:0] o);
    for (int p = 0; p < 8; p++) if (v[(p + o) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(logic [7:0] r, logic [7:0] m, logic [7:0] s, logic [2:0] o,
                     logic ne, logic ms, string tag);
    int rc, ri, rt;
    logic [7:0] s_cmp;
    bit ev;
    s_cmp = (ne && ms) ? (s & 8'hFB) : s;
    rc = rank_of(r & ~m, o);
    ri = rank_of(s_cmp, o);
    rt = rank_of(s, o);
    ev = (rc < 8) && (rc < ri);
    @(negedge clk);
    req = r; mask = m; isr = s; ofs = o; nest = ne; mst = ms;
    @(posedge clk);
    #1;
    chk({tag, " valid"}, int'(irq_valid), int'(ev));
    if (ev) chk({tag, " R6 line"}, int'(irq_num), (rc + o) % 8);
    chk({tag, " R7 top valid"}, int'(top_valid), int'(s != 0));
    if (s != 0) chk({tag, " R7 top line"}, int'(top_num), (rt + o) % 8);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    req = 8'hFF; isr = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset valid", int'(irq_valid), 0);
    chk("R9 reset top valid", int'(top_valid), 0);
    chk("R9 reset line", int'(irq_num), 0);
    @(negedge clk); rst_n = 1'b1;

    run(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R3 no request");
    run(8'hFF, 8'hFF, 8'h00, 3'd0, 0, 0, "R1 all masked");
    run(8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, "R1 masked top line");
    run(8'hFF, 8'h00, 8'h00, 3'd0, 0, 0, "R2 offset zero");
    run(8'hFF, 8'h00, 8'h00, 3'd5, 0, 0, "R2 offset five");
    run(8'h41, 8'h00, 8'h00, 3'd7, 0, 0, "R2 wrap offset seven");
    run(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, "R4 equal rank");
    run(8'h08, 8'h00, 8'h10, 3'd0, 0, 0, "R4 outranks service");
    run(8'h08, 8'h00, 8'h02, 3'd0, 0, 0, "R4 below service");
    run(8'h01, 8'h00, 8'h80, 3'd1, 0, 0, "R4 rotated service");
    run(8'h08, 8'h00, 8'h04, 3'd0, 1, 1, "R5 nested master");
    run(8'h08, 8'h00, 8'h04, 3'd0, 1, 0, "R5 nested slave");
    run(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, "R5 plain master");
    run(8'h04, 8'h00, 8'h04, 3'd0, 1, 1, "R5 cascade again");
    run(8'h00, 8'h00, 8'h05, 3'd1, 1, 1, "R7 helper keeps cascade");

    // R8: input change between edges must not reach the outputs early
    run(8'h20, 8'h00, 8'h00, 3'd0, 0, 0, "R8 setup");
    @(negedge clk);
    req = 8'h00; isr = 8'h01;
    #1;
    chk("R8 held valid", int'(irq_valid), 1);
    chk("R8 held line", int'(irq_num), 5);
    chk("R8 held top", int'(top_valid), 0);

    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r, m, s;
      r = 8'($urandom()); m = 8'($urandom()) & 8'($urandom());
      s = 8'($urandom()) & 8'($urandom()) & 8'($urandom());
      run(r, m, s, 3'($urandom()), 1'($urandom()), 1'($urandom()), "R4 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule